// File: doc/BRIEF.md
# Strobed Handshake Parallel Port Pair

This block provides two parallel ports of DATA_W bits for a controller running from on-chip memory. The output port holds a value written over a small register bus and can mark each write with a one-cycle strobe pulse. The bidirectional port has a per-bit direction register. Its pins can be captured into a separate latch register when the input strobe line shows an edge. A status flag marks a fresh capture.

A control register selects one of two modes. In simple strobed mode, writes to the output port pulse the output strobe. In full handshake mode, the output strobe instead works as a "ready" level that answers the input strobe: it drops when a capture arrives and comes back once software has taken the captured byte. The same register selects which input strobe edge counts and the output strobe polarity. It also has an open-drain option that turns every driven one on the bidirectional port into high impedance. That option works only while the `single_chip` input is high.

The register bus has an address, a write enable, a read enable and data. Read data is combinational from the address. The read enable only has an effect on the flag-clearing sequence.

Top module: `pio_hs_port`

## Requirements
- R1: After reset all registers are zero: control, output port, bidirectional data, direction (all bits inputs), latch and flag. With polarity 0 the output strobe idles high, `out_pad` is 0 and `bi_pad_oe` is 0.
- R2: A write to address 2 updates `out_pad` on the next clock edge. A read of address 2 returns that driven value.
- R3: In simple mode (control bit 0 = 0), each write to address 2 puts `ostb` at its active level for exactly the one cycle that follows the write edge. With no such write, `ostb` sits at its inactive level.
- R4: Control bit 3 sets the strobe polarity: 1 means active high, 0 means active low.
- R5: Control bit 1 selects the input strobe edge: 1 is rising, 0 is falling. On the selected edge, `bi_pin_in` is copied into the latch register, which is read at address 5. The other edge leaves the latch unchanged. The input strobe passes through a two-stage synchronizer.
- R6: A capture sets the flag, which is status bit 0 at address 1. The flag clears only when a read of address 1 sees it set and a later read of address 5 follows. A read of address 5 alone does not clear it.
- R7: A read of address 3 returns the written data on bits whose direction bit is 1 (address 4) and `bi_pin_in` on bits whose direction bit is 0.
- R8: With open drain inactive, `bi_pad_oe` equals the direction register and `bi_pad_out` equals the written data. A bit configured as an input is never driven.
- R9: Open drain is active only when control bit 2 = 1 and `single_chip` = 1. It then applies to all bits together: a written 1 gives `bi_pad_oe` = 0, and a written 0 gives `bi_pad_oe` = 1 with `bi_pad_out` = 0. When `single_chip` = 0, control bit 2 has no effect.
- R10: In full handshake mode (control bit 0 = 1), `ostb` is active while the flag is clear and inactive while it is set. Writes to address 2 cause no pulse. Input strobe edges that arrive while the flag is set neither capture nor change the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_chip | input | 1 | High when the controller runs in single-chip mode |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write enable |
| rd_en | input | 1 | Register read strobe (flag clearing) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| out_pad | output | DATA_W | Output port drive |
| ostb | output | 1 | Output strobe / handshake ready |
| istb | input | 1 | Input strobe |
| bi_pin_in | input | DATA_W | Level seen on bidirectional pins |
| bi_pad_out | output | DATA_W | Bidirectional pad drive value |
| bi_pad_oe | output | DATA_W | Bidirectional pad drive enable |

## Verification
The hardest case to reach is an input strobe edge that arrives in handshake mode while an earlier capture is still unread. The stimulus has to set handshake mode, make one capture without reading it, change the pins, and then strobe again. Only then does a latch read show whether the second edge was correctly dropped. The bench does this in a directed sequence and then runs the status-then-latch read pair to restore the ready level. Random register traffic covers the drive and readback combinations of direction, data and open drain.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_OUT  = 3'd2,
    A_BIO  = 3'd3,
    A_DIR  = 3'd4,
    A_LAT  = 3'd5
  } reg_addr_e;

  // control fields, bit 3 down to bit 0
  typedef struct packed {
    logic ostb_pol;
    logic od_en;
    logic edge_rise;
    logic hs_mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pio_istb_edge.sv
module pio_istb_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic istb,
  input  logic edge_rise,
  output logic evt
);
  logic [SYNC_STAGES:0] sh_q;
  logic [SYNC_STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], istb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[SYNC_STAGES-1] is the synchronized level, sh_q[SYNC_STAGES] its previous value
  always_comb begin
    if (edge_rise) evt = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    else           evt = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
  end
endmodule

// File: rtl/pio_latch_ctl.sv
module pio_latch_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         hs_mode,
  input  logic [W-1:0] pins,
  input  logic         stat_rd,
  input  logic         lat_rd,
  output logic [W-1:0] latch_q,
  output logic         flag_q
);
  logic         armed_q, armed_d, flag_d;
  logic         take, latch_en;
  logic [W-1:0] latch_d;

  always_comb begin
    take     = evt & ~(hs_mode & flag_q);
    latch_en = take;
    latch_d  = pins;
    flag_d   = flag_q;
    armed_d  = armed_q;
    if (lat_rd && armed_q) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (stat_rd && flag_q) armed_d = 1'b1;
    if (take) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end
endmodule

// File: rtl/pio_ostb_gen.sv
module pio_ostb_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_out,
  input  logic hs_mode,
  input  logic pol,
  input  logic flag,
  output logic ostb
);
  logic pulse_q, pulse_d, active;

  always_comb begin
    pulse_d = wr_out & ~hs_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  always_comb begin
    active = hs_mode ? ~flag : pulse_q;
    ostb   = pol ? active : ~active;
  end
endmodule

// File: rtl/pio_bi_pads.sv
module pio_bi_pads #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] data,
  input  logic         od_act,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (od_act) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = dir[i] & ~data[i];
      end else begin
        pad_out[i] = data[i];
        pad_oe[i]  = dir[i];
      end
    end
  end
endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port
  import pio_hs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_chip,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] out_pad,
  output logic              ostb,
  input  logic              istb,
  input  logic [DATA_W-1:0] bi_pin_in,
  output logic [DATA_W-1:0] bi_pad_out,
  output logic [DATA_W-1:0] bi_pad_oe
);
  localparam int PAD_W = DATA_W - CTRL_W;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] out_q, bio_q, dir_q, latch_q;
  logic              flag_q, strobe_evt, od_act;
  logic              ctrl_we, out_we, bio_we, dir_we, stat_rd, lat_rd;

  always_comb begin
    ctrl_we = wr_en && (addr == A_CTRL);
    out_we  = wr_en && (addr == A_OUT);
    bio_we  = wr_en && (addr == A_BIO);
    dir_we  = wr_en && (addr == A_DIR);
    stat_rd = rd_en && (addr == A_STAT);
    lat_rd  = rd_en && (addr == A_LAT);
    od_act  = ctrl_q.od_en & single_chip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_we) out_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bio_q <= '0;
    else if (bio_we) bio_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= wdata;
  end

  pio_istb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .istb      (istb),
    .edge_rise (ctrl_q.edge_rise),
    .evt       (strobe_evt)
  );

  pio_latch_ctl #(.W(DATA_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (strobe_evt),
    .hs_mode (ctrl_q.hs_mode),
    .pins    (bi_pin_in),
    .stat_rd (stat_rd),
    .lat_rd  (lat_rd),
    .latch_q (latch_q),
    .flag_q  (flag_q)
  );

  pio_ostb_gen u_ostb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_out  (out_we),
    .hs_mode (ctrl_q.hs_mode),
    .pol     (ctrl_q.ostb_pol),
    .flag    (flag_q),
    .ostb    (ostb)
  );

  pio_bi_pads #(.W(DATA_W)) u_pads (
    .dir     (dir_q),
    .data    (bio_q),
    .od_act  (od_act),
    .pad_out (bi_pad_out),
    .pad_oe  (bi_pad_oe)
  );

  assign out_pad = out_q;

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {{PAD_W{1'b0}}, ctrl_q};
      A_STAT:  rdata = {{(DATA_W-1){1'b0}}, flag_q};
      A_OUT:   rdata = out_q;
      A_BIO:   rdata = (dir_q & bio_q) | (~dir_q & bi_pin_in);
      A_DIR:   rdata = dir_q;
      A_LAT:   rdata = latch_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_hs_port_chk.sv
module pio_hs_port_chk
  import pio_hs_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              single_chip,
  input logic              ostb,
  input logic [W-1:0]      bi_pad_oe,
  input logic [W-1:0]      bi_pad_out,
  input logic [W-1:0]      dir_q,
  input logic              hs_mode,
  input logic              pol,
  input logic              od_en,
  input logic              flag,
  input logic              evt,
  input logic [W-1:0]      latch
);
  logic wr_out;
  assign wr_out = wr_en && (addr == A_OUT);

  // R3 / R4: a write in simple mode yields the active level next cycle
  p_strobe_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && !hs_mode) |=> (ostb == pol));

  // R3: no write, no pulse
  p_no_spurious_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_mode && !$past(hs_mode) && !$past(wr_out)) |-> (ostb != pol));

  // R8: input bits are never driven
  p_input_not_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q & bi_pad_oe) == '0));

  // R9: open drain never drives a one
  p_od_no_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (od_en && single_chip) |-> ((bi_pad_oe & bi_pad_out) == '0));

  // R6: a capture sets the flag
  p_flag_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !(hs_mode && flag)) |=> flag);

  // R5: no event, latch holds
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(latch));

  // R10: handshake ready follows the flag
  p_hs_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mode |-> (ostb == (pol ? !flag : flag)));
endmodule

bind pio_hs_port pio_hs_port_chk #(.W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wr_en       (wr_en),
  .single_chip (single_chip),
  .ostb        (ostb),
  .bi_pad_oe   (bi_pad_oe),
  .bi_pad_out  (bi_pad_out),
  .dir_q       (dir_q),
  .hs_mode     (ctrl_q.hs_mode),
  .pol         (ctrl_q.ostb_pol),
  .od_en       (ctrl_q.od_en),
  .flag        (flag_q),
  .evt         (strobe_evt),
  .latch       (latch_q)
);

// File: tb/pio_hs_port_bench.sv
module pio_hs_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         single_chip = 1'b1;
  logic [2:0]   addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, out_pad, bi_pad_out, bi_pad_oe;
  logic         ostb;
  logic         istb = 1'b0;
  logic [W-1:0] bi_pin_in = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pio_hs_port u_pio_hs_port (
    .clk(clk), .rst_n(rst_n), .single_chip(single_chip), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .out_pad(out_pad), .ostb(ostb), .istb(istb), .bi_pin_in(bi_pin_in),
    .bi_pad_out(bi_pad_out), .bi_pad_oe(bi_pad_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic strobe(input logic lvl);
    @(negedge clk); istb = lvl;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [W-1:0] exp_bi_rd(logic [W-1:0] dir, logic [W-1:0] d, logic [W-1:0] p);
    return (dir & d) | (~dir & p);
  endfunction
  function automatic logic [W-1:0] exp_oe(logic [W-1:0] dir, logic [W-1:0] d, bit od);
    return od ? (dir & ~d) : dir;
  endfunction
  function automatic logic [W-1:0] exp_out(logic [W-1:0] d, bit od);
    return od ? '0 : d;
  endfunction

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v, dir, dat, pins, a1, b1;
    bit od, sc, pol;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ostb === 1'b1, "R1 ostb idle", {7'b0, ostb}, 8'h01);
    chk(out_pad === 8'h00, "R1 out_pad", out_pad, 8'h00);
    chk(bi_pad_oe === 8'h00, "R1 bi_pad_oe", bi_pad_oe, 8'h00);
    rd(3'd0, v); chk(v === 8'h00, "R1 ctrl", v, 8'h00);
    rd(3'd1, v); chk(v === 8'h00, "R1 flag", v, 8'h00);
    rd(3'd5, v); chk(v === 8'h00, "R1 latch", v, 8'h00);

    // R2 R3 R4: random output writes, random polarity, simple mode
    for (int i = 0; i < 60; i++) begin
      pol = $urandom_range(0, 1);
      wr(3'd0, {4'b0, pol, 3'b000});
      @(negedge clk);
      chk(ostb === ~pol, "R4 idle level", {7'b0, ostb}, {7'b0, ~pol});
      v = $urandom;
      wr(3'd2, v);
      chk(ostb === pol, "R3 pulse active", {7'b0, ostb}, {7'b0, pol});
      chk(out_pad === v, "R2 out_pad", out_pad, v);
      @(negedge clk);
      chk(ostb === ~pol, "R3 pulse one cycle", {7'b0, ostb}, {7'b0, ~pol});
      rd(3'd2, a1); chk(a1 === v, "R2 readback", a1, v);
    end

    // R7 R8 R9: random direction/data/pins/open drain
    for (int i = 0; i < 80; i++) begin
      dir = $urandom; dat = $urandom; pins = $urandom;
      od = $urandom_range(0, 1); sc = $urandom_range(0, 1);
      wr(3'd0, {5'b0, od, 2'b00});
      wr(3'd4, dir);
      wr(3'd3, dat);
      @(negedge clk); single_chip = sc; bi_pin_in = pins; #1;
      chk(bi_pad_oe === exp_oe(dir, dat, od && sc), (od && sc) ? "R9 oe" : "R8 oe", bi_pad_oe, exp_oe(dir, dat, od && sc));
      chk(bi_pad_out === exp_out(dat, od && sc), (od && sc) ? "R9 out" : "R8 out", bi_pad_out, exp_out(dat, od && sc));
      rd(3'd3, v); chk(v === exp_bi_rd(dir, dat, pins), "R7 bi read", v, exp_bi_rd(dir, dat, pins));
    end
    // R9 directed: open drain ignored outside single-chip
    wr(3'd4, 8'hFF); wr(3'd3, 8'hA5); wr(3'd0, 8'h04);
    @(negedge clk); single_chip = 1'b0; #1;
    chk(bi_pad_oe === 8'hFF && bi_pad_out === 8'hA5, "R9 od ignored", bi_pad_oe, 8'hFF);
    single_chip = 1'b1; #1;
    chk(bi_pad_oe === 8'h5A && bi_pad_out === 8'h00, "R9 od all bits", bi_pad_oe, 8'h5A);
    wr(3'd4, 8'h00); wr(3'd0, 8'h00);

    // R5: falling edge selected
    a1 = 8'h3C; b1 = 8'hC3;
    bi_pin_in = a1;
    strobe(1'b1);
    rd(3'd5, v); chk(v === 8'h00, "R5 wrong edge ignored", v, 8'h00);
    strobe(1'b0);
    rd(3'd5, v); chk(v === a1, "R5 falling capture", v, a1);
    wr(3'd0, 8'h02);
    bi_pin_in = b1;
    strobe(1'b1);
    rd(3'd5, v); chk(v === b1, "R5 rising capture", v, b1);
    strobe(1'b0);
    rd(3'd5, v); chk(v === b1, "R5 falling ignored", v, b1);

    // R6 flag clear sequence
    rd(3'd5, v);
    rd(3'd1, v); chk(v === 8'h01, "R6 latch read alone keeps flag", v, 8'h01);
    rd(3'd5, v);
    rd(3'd1, v); chk(v === 8'h00, "R6 flag cleared", v, 8'h00);

    // R10 full handshake, rising edge, active-high
    wr(3'd0, 8'h0B);
    @(negedge clk);
    chk(ostb === 1'b1, "R10 ready when empty", {7'b0, ostb}, 8'h01);
    bi_pin_in = 8'h77;
    strobe(1'b1); strobe(1'b0);
    chk(ostb === 1'b0, "R10 not ready after capture", {7'b0, ostb}, 8'h00);
    wr(3'd2, 8'h12);
    chk(ostb === 1'b0, "R10 write gives no pulse", {7'b0, ostb}, 8'h00);
    bi_pin_in = 8'h88;
    strobe(1'b1); strobe(1'b0);
    rd(3'd5, v); chk(v === 8'h77, "R10 edge while full ignored", v, 8'h77);
    rd(3'd1, v); rd(3'd5, v);
    @(negedge clk);
    chk(ostb === 1'b1, "R10 ready restored", {7'b0, ostb}, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule